// File: doc/BRIEF.md
# Depth-Cascade Token Ring Controller

This block is the control logic for a group of identical FIFO slices that share one write strobe and one read strobe and together act as a single deeper FIFO. Each slice has its own pointers, occupancy count, write token and read token. The slice that holds the write token takes the next shared write. The slice that holds the read token serves the next shared read. When a slice fills its last location, it hands the write token on to the next slice in the ring. When it empties its last location, it hands the read token on in the same way. The slices are chained by an active-low expansion line, running from each slice's expansion output to the next slice's expansion input.

The grouping mode is captured while reset is held. A slice whose expansion input is low at that time works on its own. In that standalone mode its expansion output reports half-full instead of carrying tokens. A slice whose expansion input is high becomes the lead slice if its first-load pin is low, and a follower slice otherwise. The block gives each slice its write and read enables and addresses for local storage that lies outside the block. It also merges the per-slice active-low full and empty flags into composite flags.

Top module: `fifo_cascade_ring`

## Requirements
- R1: On each clock edge while rst_ni is low, every slice samples its mode: xi_ni low gives standalone, xi_ni high with lead_ni low gives lead, and both high gives follower. The mode then holds until the next reset.
- R2: While rst_ni is low, every xo_no is high and no write or read enable is raised, whatever the strobes are doing.
- R3: After reset in cascade mode, only the lead slice holds the two tokens. The composite empty is asserted (empty_no = 0) and the composite full is clear (full_no = 1). The first accepted write goes to the lead slice at address 0.
- R4: A cycle with wr_i = 1 and rd_i = 0 raises at most one wr_en_o bit, on the write-token slice, only if that slice holds fewer than DEPTH words. Its write address steps 0, 1, …, DEPTH-1 and wraps to 0. Reads behave the same way with rd_en_o, the read-token slice and a nonzero count.
- R5: In the cycle of an accepted write to address DEPTH-1, that slice drives its xo_no low. From the next cycle on, the write token belongs to the slice whose xi_ni was low while the write strobe was high.
- R6: In the cycle of an accepted read from address DEPTH-1, that slice drives its xo_no low. From the next cycle on, the read token belongs to the slice whose xi_ni was low while the read strobe was high.
- R7: A cycle with wr_i and rd_i both high performs no access: no enable is raised, and no count, pointer or flag changes.
- R8: slice_full_no[i] is low exactly when slice i holds the write token and stores DEPTH words. slice_empty_no[i] is low exactly when slice i holds the read token and stores no words. full_no is the AND of the slice_full_no bits, and empty_no is the AND of the slice_empty_no bits.
- R9: Writes are refused while full_no is low, and reads are refused while empty_no is low. Words come out of the ring in the order they were written, across slice boundaries and wraps.
- R10: In standalone mode, a slice keeps both tokens permanently, and its xo_no is low exactly when it stores more than DEPTH/2 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; mode pins are sampled while low |
| wr_i | input | 1 | Shared write strobe, one cycle per word |
| rd_i | input | 1 | Shared read strobe, one cycle per word |
| xi_ni | input | SLICES | Per-slice expansion input, active low |
| lead_ni | input | SLICES | Per-slice first-load select, low marks the lead slice |
| xo_no | output | SLICES | Per-slice expansion output (token pulse) or half-full in standalone |
| wr_en_o | output | SLICES | Per-slice storage write enable |
| rd_en_o | output | SLICES | Per-slice storage read enable |
| waddr_o | output | SLICES*AW | Per-slice write address, slice i at bits [i*AW +: AW] |
| raddr_o | output | SLICES*AW | Per-slice read address, slice i at bits [i*AW +: AW] |
| slice_full_no | output | SLICES | Per-slice full flag, active low |
| slice_empty_no | output | SLICES | Per-slice empty flag, active low |
| full_no | output | 1 | Composite full flag, active low |
| empty_no | output | 1 | Composite empty flag, active low |

## Verification
The bench closes three slices of depth four into a ring. It first fills the whole ring and then drains it, which shows every token handover and the full and empty boundaries. Next it alternates short write and read bursts so that both tokens circle the ring several times; this tells a slice that passes its token too early or too late apart from a correct one, because the read data order breaks at once. A reset with a different lead slice and a reset with all slices standalone show that mode capture, and not the slice position, decides token ownership and the meaning of xo_no. Cycles with both strobes high, writes into a full ring and reads from an empty one show that nothing moves when an access is not allowed.

// File: rtl/fifo_ring_pkg.sv
package fifo_ring_pkg;
  typedef enum logic [1:0] {
    MODE_ALONE  = 2'd0,
    MODE_LEAD   = 2'd1,
    MODE_FOLLOW = 2'd2
  } ring_mode_e;

  function automatic ring_mode_e decode_mode(input logic xi_n, input logic lead_n);
    if (!xi_n)   return MODE_ALONE;
    if (!lead_n) return MODE_LEAD;
    return MODE_FOLLOW;
  endfunction
endpackage

// File: rtl/ring_mode_latch.sv
module ring_mode_latch
  import fifo_ring_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       xi_ni,
  input  logic       lead_ni,
  output ring_mode_e mode_o
);
  ring_mode_e mode_q;

  // sampled on every edge inside reset, frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= decode_mode(xi_ni, lead_ni);
  end

  assign mode_o = mode_q;

  a_r1_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mode_q));
endmodule

// File: rtl/ring_slice_ctrl.sv
module ring_slice_ctrl
  import fifo_ring_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          xi_ni,
  input  logic          lead_ni,
  output logic          xo_no,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic          full_no,
  output logic          empty_no
);
  ring_mode_e mode;
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic wflip_q, rflip_q;
  logic cascade, lead, wtok, rtok, full, empty, half;
  logic wr_op, rd_op, wlast, rlast, wpass, rpass, wgain, rgain;

  ring_mode_latch u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .xi_ni  (xi_ni),
    .lead_ni(lead_ni),
    .mode_o (mode)
  );

  assign cascade = (mode != MODE_ALONE);
  assign lead    = (mode == MODE_LEAD);

  // token = flip ^ reset owner; standalone always owns both
  assign wtok = cascade ? (wflip_q ^ lead) : 1'b1;
  assign rtok = cascade ? (rflip_q ^ lead) : 1'b1;

  assign wr_op = rst_ni & wr_i & ~rd_i;
  assign rd_op = rst_ni & rd_i & ~wr_i;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign half  = (cnt_q > CW'(DEPTH / 2));

  assign wr_en_o = wr_op & wtok & ~full;
  assign rd_en_o = rd_op & rtok & ~empty;

  assign wlast = (wptr_q == AW'(DEPTH - 1));
  assign rlast = (rptr_q == AW'(DEPTH - 1));
  assign wpass = cascade & wr_en_o & wlast;
  assign rpass = cascade & rd_en_o & rlast;
  // incoming pulse belongs to whichever strobe is active now
  assign wgain = cascade & wr_op & ~xi_ni;
  assign rgain = cascade & rd_op & ~xi_ni;

  assign xo_no    = cascade ? ~(wpass | rpass) : ~half;
  assign waddr_o  = wptr_q;
  assign raddr_o  = rptr_q;
  assign full_no  = ~(wtok & full);
  assign empty_no = ~(rtok & empty);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      wflip_q <= 1'b0;
      rflip_q <= 1'b0;
    end else begin
      if (wr_en_o) wptr_q <= wlast ? '0 : wptr_q + AW'(1);
      if (rd_en_o) rptr_q <= rlast ? '0 : rptr_q + AW'(1);
      if (wr_en_o)      cnt_q <= cnt_q + CW'(1);
      else if (rd_en_o) cnt_q <= cnt_q - CW'(1);
      wflip_q <= wflip_q ^ wgain ^ wpass;
      rflip_q <= rflip_q ^ rgain ^ rpass;
    end
  end

  a_r4_count_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> cnt_q == $past(cnt_q) + CW'(1));
  a_r5_wpass_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wpass && xi_ni) |=> !wtok);
  a_r5_wgain_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wgain && !wpass) |=> wtok);
  a_r6_rpass_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpass && xi_ni) |=> !rtok);
  a_r7_both_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i) |=> ($stable(cnt_q) && $stable(wptr_q) && $stable(rptr_q)));
endmodule

// File: rtl/ring_flag_merge.sv
module ring_flag_merge #(
  parameter int SLICES = 3
) (
  input  logic [SLICES-1:0] full_ni,
  input  logic [SLICES-1:0] empty_ni,
  output logic              full_no,
  output logic              empty_no
);
  // active-low flags: any asserted slice asserts the group
  assign full_no  = &full_ni;
  assign empty_no = &empty_ni;
endmodule

// File: rtl/fifo_cascade_ring.sv
module fifo_cascade_ring #(
  parameter int SLICES = 3,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [SLICES-1:0]    xi_ni,
  input  logic [SLICES-1:0]    lead_ni,
  output logic [SLICES-1:0]    xo_no,
  output logic [SLICES-1:0]    wr_en_o,
  output logic [SLICES-1:0]    rd_en_o,
  output logic [SLICES*AW-1:0] waddr_o,
  output logic [SLICES*AW-1:0] raddr_o,
  output logic [SLICES-1:0]    slice_full_no,
  output logic [SLICES-1:0]    slice_empty_no,
  output logic                 full_no,
  output logic                 empty_no
);
  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    ring_slice_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_i),
      .rd_i    (rd_i),
      .xi_ni   (xi_ni[i]),
      .lead_ni (lead_ni[i]),
      .xo_no   (xo_no[i]),
      .wr_en_o (wr_en_o[i]),
      .rd_en_o (rd_en_o[i]),
      .waddr_o (waddr_o[i*AW +: AW]),
      .raddr_o (raddr_o[i*AW +: AW]),
      .full_no (slice_full_no[i]),
      .empty_no(slice_empty_no[i])
    );
  end

  ring_flag_merge #(.SLICES(SLICES)) u_merge (
    .full_ni (slice_full_no),
    .empty_ni(slice_empty_no),
    .full_no (full_no),
    .empty_no(empty_no)
  );

  a_r9_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> (wr_en_o == '0));
  a_r9_empty_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_no |-> (rd_en_o == '0));
endmodule

// File: tb/tb_fifo_cascade_ring.sv
module tb_fifo_cascade_ring;
  localparam int CLK_PERIOD = 10;
  localparam int S  = 3;
  localparam int D  = 4;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic alone = 1'b0;
  logic [S-1:0] xi_n, lead_n, xo_n, wr_en, rd_en, sf_n, se_n;
  logic [S*AW-1:0] waddr, raddr;
  logic full_n, empty_n;
  logic [7:0] din = '0;
  logic [7:0] mem [S][D];
  logic [7:0] rq [0:255];

  int n_chk = 0, n_fail = 0;
  int qh = 0, qt = 0, total = 0;
  int wo = 0, wa = 0, ro = 0, ra = 0;
  int sc [S];
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < S; i++) xi_n[i] = alone ? 1'b0 : xo_n[(i + S - 1) % S];
  end

  always @(posedge clk) begin
    for (int i = 0; i < S; i++)
      if (wr_en[i]) mem[i][waddr[i*AW +: AW]] <= din;
  end

  fifo_cascade_ring #(.SLICES(S), .DEPTH(D)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd),
    .xi_ni(xi_n), .lead_ni(lead_n), .xo_no(xo_n),
    .wr_en_o(wr_en), .rd_en_o(rd_en), .waddr_o(waddr), .raddr_o(raddr),
    .slice_full_no(sf_n), .slice_empty_no(se_n),
    .full_no(full_n), .empty_no(empty_n)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit stand, int lead_idx);
    @(negedge clk);
    rst_n = 1'b0; alone = stand; wr = 1'b1; rd = 1'b0;
    lead_n = '1; lead_n[lead_idx] = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    chk("R2 xo high in reset", int'(xo_n), (1 << S) - 1);
    chk("R2 no enable in reset", int'(wr_en | rd_en), 0);
    wr = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    qh = 0; qt = 0; total = 0; wo = lead_idx; wa = 0; ro = lead_idx; ra = 0;
    for (int i = 0; i < S; i++) sc[i] = 0;
    #1;
    chk("R3 reset empty", int'(empty_n), 0);
    chk("R3 reset not full", int'(full_n), 1);
  endtask

  // one cascade access cycle with the full reference model
  task automatic cop(bit w, bit r, logic [7:0] d);
    bit wacc, racc;
    int exp_xo, exp_sf, exp_se;
    @(negedge clk);
    wr = w; rd = r; din = d; #1;
    wacc = w && !r && total < S * D;
    racc = r && !w && total > 0;
    chk("R4/R9 write enable", int'(wr_en), wacc ? (1 << wo) : 0);
    chk("R4/R9 read enable", int'(rd_en), racc ? (1 << ro) : 0);
    if (wacc) chk("R4 write address", int'(waddr[wo*AW +: AW]), wa);
    if (racc) begin
      chk("R4 read address", int'(raddr[ro*AW +: AW]), ra);
      chk("R9 read order", int'(mem[ro][ra]), int'(rq[qh]));
    end
    exp_xo = (1 << S) - 1;
    if (wacc && wa == D - 1) exp_xo &= ~(1 << wo);
    if (racc && ra == D - 1) exp_xo &= ~(1 << ro);
    chk("R5/R6 expansion pulse", int'(xo_n), exp_xo);
    @(posedge clk);
    if (wacc) begin
      rq[qt] = d; qt = (qt + 1) % 256; total++; sc[wo]++;
      if (wa == D - 1) begin wa = 0; wo = (wo + 1) % S; end else wa++;
    end
    if (racc) begin
      qh = (qh + 1) % 256; total--; sc[ro]--;
      if (ra == D - 1) begin ra = 0; ro = (ro + 1) % S; end else ra++;
    end
    #1;
    exp_sf = (1 << S) - 1; exp_se = (1 << S) - 1;
    if (sc[wo] == D) exp_sf &= ~(1 << wo);
    if (sc[ro] == 0) exp_se &= ~(1 << ro);
    chk("R8 slice full flags", int'(sf_n), exp_sf);
    chk("R8 slice empty flags", int'(se_n), exp_se);
    chk("R8 composite full", int'(full_n), int'(total != S * D));
    chk("R8 composite empty", int'(empty_n), int'(total != 0));
  endtask

  task automatic idle();
    @(negedge clk); wr = 1'b0; rd = 1'b0;
  endtask

  task automatic t_fill_drain();
    do_reset(0, 0);
    cop(0, 1, 8'h00);                       // R9 read on empty refused
    for (int k = 0; k < S * D; k++) cop(1, 0, 8'(8'h10 + k));  // R5 handovers
    cop(1, 0, 8'hEE);                       // R9 write on full refused
    cop(1, 1, 8'hDD);                       // R7 both strobes
    for (int k = 0; k < 5; k++) cop(0, 1, 8'h00);  // R6 handover
    for (int k = 0; k < 3; k++) cop(1, 0, 8'(8'h40 + k));
    for (int k = 0; k < 11; k++) cop(0, 1, 8'h00);
    cop(0, 1, 8'h00);                       // R9 drained
    idle();
  endtask

  task automatic t_laps();
    do_reset(0, 0);
    for (int k = 0; k < 15; k++) begin
      cop(1, 0, 8'(8'h80 + 2 * k));
      cop(1, 0, 8'(8'h81 + 2 * k));
      cop(1, 1, 8'h00);                     // R7 in the middle of traffic
      cop(0, 1, 8'h00);
      cop(0, 1, 8'h00);
    end
    idle();
  endtask

  task automatic t_other_lead();
    do_reset(0, 1);                         // R1 slice 1 latched as lead
    for (int k = 0; k < 5; k++) cop(1, 0, 8'(8'hA0 + k));
    for (int k = 0; k < 5; k++) cop(0, 1, 8'h00);
    idle();
  endtask

  task automatic t_standalone();
    do_reset(1, 0);                         // R1 xi low -> standalone
    for (int k = 0; k < D; k++) begin
      @(negedge clk); wr = 1'b1; din = 8'(8'hC0 + k); #1;
      chk("R10 all slices write", int'(wr_en), (1 << S) - 1);
      chk("R10 slice 2 address", int'(waddr[2*AW +: AW]), k);
      @(posedge clk); #1;
      chk("R10 half-full on xo", int'(xo_n), (k + 1 > D / 2) ? 0 : (1 << S) - 1);
    end
    chk("R8 standalone full", int'(full_n), 0);
    @(negedge clk); wr = 1'b1; #1;
    chk("R9 standalone write refused", int'(wr_en), 0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); wr = 1'b0; rd = 1'b1; #1;
      chk("R10 all slices read", int'(rd_en), (1 << S) - 1);
      chk("R10 read data", int'(mem[1][raddr[1*AW +: AW]]), 8'hC0 + k);
      @(posedge clk); #1;
      chk("R10 half-full after read", int'(xo_n), (D - 1 - k > D / 2) ? 0 : (1 << S) - 1);
    end
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    lead_n = 3'b110;
    t_fill_drain();
    t_laps();
    t_other_lead();
    t_standalone();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end
endmodule